// File: doc/BRIEF.md
# Microscaled Four-Bit Block Dequantizer

This block expands one compressed block of sixteen 4-bit floating-point codes into sixteen IEEE-754 single-precision words. The block also carries an 8-bit floating-point scale. Each element code has one sign bit, two exponent bits and one mantissa bit. On its own it holds only the relative size of its value, up to a magnitude of 6. The single scale code in the block sets the absolute magnitude of all sixteen elements. Each output is the decoded element multiplied by the decoded scale. Every such product fits exactly into a 24-bit significand, so the datapath has no rounding logic.

A producer streams blocks of 72 bits each, at a cost of 4.5 bits per element. It uses a valid/ready handshake and moves one block per transfer. A consumer takes the 512-bit result through a second valid/ready handshake. The datapath has two register stages. It can accept a new block on every clock while the consumer is ready, and it stalls without losing data when the consumer applies backpressure.

Top module: `mx4_block_dequant`

## Requirements
- R1: Element i occupies bits [4i+3:4i] of `inBlock`. Its bit 3 is the sign, bits 2:1 the exponent E and bit 0 the mantissa m. E=0 gives magnitude 0.5·m. E>0 gives (1+m/2)·2^(E-1). The magnitudes are therefore {0,0.5,1,1.5,2,3,4,6}.
- R2: The scale occupies bits [71:64]. Its bit 7 is the sign, bits 6:3 the exponent E and bits 2:0 the mantissa m. E=0 gives magnitude (m/8)·2^-6. E>0 gives (1+m/8)·2^(E-7).
- R3: Output lane i, at bits [32i+31:32i] of `outData`, is the exact single-precision encoding of element i times the scale.
- R4: A scale whose bits 6:0 are all ones is NaN. It forces every lane to 32'h7FC00000.
- R5: If the product is zero, the lane is a zero whose sign bit is the XOR of the element sign and the scale sign.
- R6: A block is taken only on a clock edge where `inValid` and `inReady` are both high. `inReady` is low only while both stages are full and `outReady` is low.
- R7: While `outValid` is high and `outReady` is low, `outValid` and `outData` stay unchanged.
- R8: A block accepted on clock edge t appears on the outputs after edge t+1, provided it is not stalled.
- R9: During reset and right after it, `outValid` is low and `inReady` is high.
- R10: While `outReady` is high, `inReady` is high, so the block sustains one block per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Producer offers a block |
| inReady | output | 1 | Block can take a block this cycle |
| inBlock | input | 72 | Packed scale and sixteen element codes |
| outValid | output | 1 | Result block present |
| outReady | input | 1 | Consumer takes the result this cycle |
| outData | output | 512 | Sixteen single-precision results, lane 0 in the low bits |

## Verification
A wrong stage valid bit shows up at the ports within one or two cycles. It appears as a lost or duplicated block in the scoreboard, as a missed latency, or as `inReady` falling while the consumer is ready. A corrupted datapath register shows up as a lane mismatch on the next result. Errors in decoding bias or subnormal handling affect only particular code values. For that reason, directed blocks sweep all sixteen element codes and the extreme, subnormal, zero and NaN scale codes. Random traffic with random backpressure covers everything else.

// File: rtl/mx4_pkg.sv
package mx4_pkg;
  localparam int LANES     = 16;
  localparam int ELEM_W    = 4;
  localparam int SCALE_W   = 8;
  localparam int WORD_W    = 32;
  localparam int ELEMS_W   = LANES * ELEM_W;
  localparam int BLOCK_W   = ELEMS_W + SCALE_W;
  localparam int OUT_W     = LANES * WORD_W;
  localparam logic [WORD_W-1:0] QUIET_NAN = 32'h7FC0_0000;

  // strobes from control to datapath
  typedef struct packed {
    logic load1;
    logic load2;
  } stageCtl_t;

  // decoded shared scale: value = sig * 2^exp (exp two's complement)
  typedef struct packed {
    logic       sign;
    logic       nan;
    logic [3:0] sig;
    logic [5:0] exp;
  } scaleDec_t;
endpackage

// File: rtl/mx4_scale_dec.sv
module mx4_scale_dec
  import mx4_pkg::*;
(
  input  logic [SCALE_W-1:0] code,
  output scaleDec_t          dec
);
  logic hidden;

  always_comb begin
    hidden   = (code[6:3] != 4'd0);
    dec.sign = code[7];
    dec.nan  = (code[6:0] == 7'h7F);
    dec.sig  = {hidden, code[2:0]};
    // integer significand carries 3 fraction bits, bias 7
    dec.exp  = hidden ? ({2'b00, code[6:3]} - 6'd10) : 6'b110111;
  end
endmodule

// File: rtl/mx4_lane.sv
module mx4_lane
  import mx4_pkg::*;
(
  input  logic [ELEM_W-1:0] elemCode,
  input  scaleDec_t         scale,
  output logic [WORD_W-1:0] word
);
  logic       eSign;
  logic [1:0] eSig;
  logic [5:0] eExp;
  logic [5:0] prod;
  logic [2:0] lead;
  logic [7:0] sumExp;
  logic [7:0] biased;
  logic [22:0] frac;
  logic       rSign;

  always_comb begin
    eSign = elemCode[3];
    eSig  = {(elemCode[2:1] != 2'b00), elemCode[0]};
    // integer significand carries 1 fraction bit, bias 1
    eExp  = (elemCode[2:1] == 2'b00) ? 6'h3F : ({4'b0, elemCode[2:1]} - 6'd2);
    prod  = {4'b0, eSig} * {2'b0, scale.sig};
    lead  = 3'd0;
    for (int b = 0; b < 6; b++) begin
      if (prod[b]) lead = 3'(b);
    end
    sumExp = {{2{eExp[5]}}, eExp} + {{2{scale.exp[5]}}, scale.exp};
    biased = sumExp + {5'b0, lead} + 8'd127;
    frac   = {17'b0, prod} << (5'd23 - {2'b0, lead});
    rSign  = eSign ^ scale.sign;
    if (scale.nan)        word = QUIET_NAN;
    else if (prod == '0)  word = {rSign, 31'b0};
    else                  word = {rSign, biased, frac};
  end
endmodule

// File: rtl/mx4_ctrl.sv
module mx4_ctrl
  import mx4_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      outReady,
  output logic      inReady,
  output logic      outValid,
  output stageCtl_t ctl
);
  logic stage1Full, stage2Full;
  logic adv1, adv2;

  always_comb begin
    adv2      = !stage2Full || outReady;
    adv1      = !stage1Full || adv2;
    inReady   = adv1;
    outValid  = stage2Full;
    ctl.load1 = inValid && adv1;
    ctl.load2 = stage1Full && adv2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Full <= 1'b0;
      stage2Full <= 1'b0;
    end else begin
      if (adv1) stage1Full <= inValid;
      if (adv2) stage2Full <= stage1Full;
    end
  end
endmodule

// File: rtl/mx4_datapath.sv
module mx4_datapath
  import mx4_pkg::*;
(
  input  logic               clk,
  input  stageCtl_t          ctl,
  input  logic [BLOCK_W-1:0] inBlock,
  output logic [OUT_W-1:0]   outData
);
  scaleDec_t          scaleIn, scaleReg;
  logic [ELEMS_W-1:0] elemReg;
  logic [OUT_W-1:0]   laneWords;

  mx4_scale_dec scaleDec_i (
    .code (inBlock[BLOCK_W-1:ELEMS_W]),
    .dec  (scaleIn)
  );

  always_ff @(posedge clk) begin
    if (ctl.load1) begin
      elemReg  <= inBlock[ELEMS_W-1:0];
      scaleReg <= scaleIn;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    mx4_lane lane_i (
      .elemCode (elemReg[i*ELEM_W +: ELEM_W]),
      .scale    (scaleReg),
      .word     (laneWords[i*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (ctl.load2) outData <= laneWords;
  end
endmodule

// File: rtl/mx4_block_dequant.sv
module mx4_block_dequant
  import mx4_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [BLOCK_W-1:0] inBlock,
  output logic               outValid,
  input  logic               outReady,
  output logic [OUT_W-1:0]   outData
);
  stageCtl_t ctl;

  mx4_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  mx4_datapath dp_i (
    .clk     (clk),
    .ctl     (ctl),
    .inBlock (inBlock),
    .outData (outData)
  );
endmodule

// File: rtl/mx4_block_dequant_chk.sv
module mx4_block_dequant_chk
  import mx4_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [OUT_W-1:0] outData
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R6
  ready_low_only_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> (outValid && !outReady));

  // R10
  ready_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> inReady);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady, 2));

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!outValid && inReady));
endmodule

bind mx4_block_dequant mx4_block_dequant_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/mx4_block_dequant_tb_top.sv
module mx4_block_dequant_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [71:0]  inBlock;
  logic         outValid;
  logic         outReady;
  logic [511:0] outData;

  int checks = 0;
  int errors = 0;
  logic [511:0] expQ[$];

  always #5 clk = ~clk;

  mx4_block_dequant dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inBlock(inBlock), .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  // element magnitude times 2 (R1)
  function automatic int elemX2(input logic [3:0] c);
    int e = int'(c[2:1]);
    if (e == 0) return int'(c[0]);
    return (2 + int'(c[0])) << (e - 1);
  endfunction

  // scale magnitude times 512 (R2)
  function automatic int scaleX512(input logic [7:0] c);
    int e = int'(c[6:3]);
    if (e == 0) return int'(c[2:0]);
    return (8 + int'(c[2:0])) << (e - 1);
  endfunction

  function automatic logic [31:0] refWord(input logic [3:0] e, input logic [7:0] s);
    longint n;
    int msb;
    logic sgn;
    longint fr;
    if (s[6:0] == 7'h7F) return 32'h7FC0_0000;
    sgn = e[3] ^ s[7];
    n = longint'(elemX2(e)) * longint'(scaleX512(s));   // value * 1024
    if (n == 0) return {sgn, 31'b0};
    msb = 0;
    for (int b = 0; b < 32; b++) if (n[b]) msb = b;
    fr = (n - (longint'(1) << msb)) << (23 - msb);
    return {sgn, 8'(msb - 10 + 127), 23'(fr)};
  endfunction

  function automatic logic [511:0] refBlock(input logic [71:0] blk);
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = refWord(blk[i*4 +: 4], blk[71:64]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one block through an empty pipeline, consumer ready (R8 timing)
  task automatic oneShot(input string req, input logic [71:0] blk);
    @(negedge clk);
    inValid = 1'b1; inBlock = blk; outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chkBit("R8 not early", outValid, 1'b0);
    @(negedge clk);
    chkBit("R8 valid after second edge", outValid, 1'b1);
    chk(req, outData, refBlock(blk));
    @(negedge clk);
    chkBit("R8 single result", outValid, 1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [71:0] ramp, blkA, blkB, blkC, blk;
    logic [511:0] prevData;
    logic prevStall;
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0; inBlock = '0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkBit("R9 valid low in reset", outValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkBit("R9 valid low after reset", outValid, 1'b0);
    chkBit("R9 ready high after reset", inReady, 1'b1);

    for (int i = 0; i < 16; i++) ramp[i*4 +: 4] = 4'(i);
    // R1 all element codes, scale 1.0, lane order
    oneShot("R1 R3 element sweep", {8'h38, ramp[63:0]});
    // R2 subnormal, largest and negative scales
    oneShot("R2 subnormal scale", {8'h01, ramp[63:0]});
    oneShot("R2 max scale", {8'h7E, ramp[63:0]});
    oneShot("R2 negative scale", {8'hB3, ramp[63:0]});
    // R4 both NaN codes
    oneShot("R4 NaN scale", {8'h7F, ramp[63:0]});
    chk("R4 lane pattern", {480'b0, outData[31:0]}, {480'b0, 32'h7FC0_0000});
    oneShot("R4 negative NaN scale", {8'hFF, ramp[63:0]});
    // R5 signed zeros
    oneShot("R5 zero scale", {8'h00, ramp[63:0]});
    oneShot("R5 negative zero scale", {8'h80, ramp[63:0]});

    // R6 R7 R10 directed backpressure
    blkA = {8'h40, ramp[63:0]}; blkB = {8'h30, ~ramp[63:0]}; blkC = {8'hC8, ramp[63:0]};
    @(negedge clk);
    outReady = 1'b0; inValid = 1'b1; inBlock = blkA;
    @(negedge clk);
    inBlock = blkB;
    @(negedge clk);
    inBlock = blkC;
    chkBit("R6 ready low when full", inReady, 1'b0);
    chk("R7 head block", outData, refBlock(blkA));
    @(negedge clk);
    chkBit("R7 valid held", outValid, 1'b1);
    chk("R7 data held", outData, refBlock(blkA));
    outReady = 1'b1;
    #1;
    chkBit("R10 ready follows consumer", inReady, 1'b1);
    @(negedge clk);
    inValid = 1'b0;
    chk("R6 second block kept", outData, refBlock(blkB));
    @(negedge clk);
    chk("R6 stalled block taken later", outData, refBlock(blkC));
    @(negedge clk);
    chkBit("R6 no extra block", outValid, 1'b0);

    // random traffic with scoreboard (R3 R7 R10)
    prevStall = 1'b0; prevData = '0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      outReady = ($urandom % 4) != 0;
      inValid  = ($urandom % 4) != 0;
      blk = 72'({$urandom, $urandom, $urandom});
      case ($urandom % 8)
        0: blk[70:64] = 7'h7F;
        1: blk[70:64] = 7'h00;
        default: ;
      endcase
      inBlock = blk;
      #1;
      if (prevStall) begin
        chkBit("R7 valid under backpressure", outValid, 1'b1);
        chk("R7 data under backpressure", outData, prevData);
      end
      if (outReady && !inReady) chkBit("R10 ready with consumer ready", inReady, 1'b1);
      if (outValid && outReady) begin
        if (expQ.size() == 0) chkBit("R6 unexpected output", 1'b1, 1'b0);
        else chk("R3 random block", outData, expQ.pop_front());
      end
      if (inValid && inReady) expQ.push_back(refBlock(blk));
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b1;
    for (int d = 0; d < 4; d++) begin
      #1;
      if (outValid) begin
        if (expQ.size() == 0) chkBit("R6 unexpected output", 1'b1, 1'b0);
        else chk("R3 drain block", outData, expQ.pop_front());
      end
      @(negedge clk);
    end
    chkBit("R6 all blocks delivered", expQ.size() == 0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule